// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a BCD calendar supplied by a separate time-keeping block and raises an alarm interrupt when the time reaches a programmed point. It holds six alarm value registers: seconds, minutes, hours, day of month, month and a three-digit year. A control register has one enable bit per field and a global enable bit. Once per second, on a one-cycle strobe from the calendar block, each enabled field is compared with its alarm register.

The alarm fires when any enabled field matches. The fields are OR-ed, not AND-ed. A hit sets a pending bit, and that bit drives the interrupt line directly. The pending bit stays set until software writes 1 to it.

Software reaches all registers through a plain single-cycle register port. Writes complete in the cycle they are presented, so the port never stalls and carries no handshake. Read data is combinational from the address. The calendar inputs are control-rate values and need no flow control. They only need to be valid in the cycle the strobe is high.

Top module: `calendar_alarm`

## Requirements
- R1: After reset, the control register, all six alarm registers and the pending bit read as zero, and `alarm_irq` is low.
- R2: Register addresses are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 status. A write to an alarm register stores only its low bits: 7 for seconds, 7 for minutes, 6 for hours, 6 for day, 5 for month and 12 for year. A write to control stores bits [6:0]. Readback returns the stored value zero-extended.
- R3: Control bit 6 is the global enable. While it is 0, no strobe can set the pending bit.
- R4: Control bits 0 to 5 enable comparison of seconds, minutes, hours, day, month and year, in that order. A field whose enable bit is 0 never causes a hit. Month is compared in its displayed BCD form, 01 to 12.
- R5: A hit occurs when the global enable is set and at least one enabled field equals its alarm register, whatever the other enabled fields hold.
- R6: The comparison happens only in a cycle where `sec_pulse` is high. Matching calendar values without the strobe have no effect.
- R7: The year is compared as a 12-bit, three-digit BCD value: hundreds in [11:8], tens and units in [7:0]. A difference in the hundreds digit alone prevents a year match.
- R8: A hit sets the pending bit, readable at status bit 1, and `alarm_irq` is high from the clock edge that samples the strobe.
- R9: Writing status with bit 1 set clears the pending bit and lowers `alarm_irq` on the next edge. A status write with bit 1 clear changes nothing.
- R10: Once set, the pending bit stays set until cleared, through any number of later strobes with or without a match.
- R11: When a hit and a clearing status write fall in the same cycle, the pending bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_pulse | input | 1 | One-cycle strobe after the calendar has advanced |
| cal_sec | input | 8 | Current BCD seconds |
| cal_min | input | 8 | Current BCD minutes |
| cal_hour | input | 8 | Current BCD hours |
| cal_mday | input | 8 | Current BCD day of month |
| cal_mon | input | 8 | Current BCD month, 01 to 12 |
| cal_year | input | 12 | Current three-digit BCD year |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt, equal to the pending bit |

## Verification
The hardest situation to reach from the ports is a hit landing in the same cycle as a clearing status write. Two other cases are also hard: a field that matches while its own enable is off but a different enable is on, and a year that differs only in the hundreds digit. The stimulus task that issues a strobe can also drive a status write in the same cycle, so set-versus-clear is forced directly. Directed cases walk each enable bit against each matching field. Constrained random rounds then draw calendar values half the time from the programmed alarm values, so matches and near misses are frequent.

// File: rtl/calalm_pkg.sv
package calalm_pkg;
  localparam int NUM_FIELDS    = 6;
  localparam int FIELD_W       = 12;
  localparam int CTRL_W        = 7;
  localparam int GLOBAL_EN_BIT = 6;
  localparam int PEND_BIT      = 1;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_SEC  = 3'd1,
    RA_MIN  = 3'd2,
    RA_HOUR = 3'd3,
    RA_MDAY = 3'd4,
    RA_MON  = 3'd5,
    RA_YEAR = 3'd6,
    RA_STAT = 3'd7
  } reg_addr_e;

  // number of bits each alarm field keeps on write
  function automatic int kept_bits(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] kept_mask(input int idx);
    return {FIELD_W{1'b1}} >> (FIELD_W - kept_bits(idx));
  endfunction
endpackage

// File: rtl/calalm_regs.sv
module calalm_regs
  import calalm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  reg_we,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [DATA_W-1:0]                     reg_wdata,
  input  logic                                  pend,
  output logic [CTRL_W-1:0]                     ctrl_q,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]    alm_q,
  output logic                                  clr_req,
  output logic [DATA_W-1:0]                     reg_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(RA_CTRL);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(RA_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_we && reg_addr == CTRL_ADDR)
      ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
    localparam logic [FIELD_W-1:0] MY_MASK = kept_mask(i);
    always_ff @(posedge clk) begin
      if (!rst_n)
        alm_q[i] <= '0;
      else if (reg_we && reg_addr == MY_ADDR)
        alm_q[i] <= reg_wdata[FIELD_W-1:0] & MY_MASK;
    end
  end

  assign clr_req = reg_we && (reg_addr == STAT_ADDR) && reg_wdata[PEND_BIT];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    end else if (reg_addr == STAT_ADDR) begin
      reg_rdata[PEND_BIT] = pend;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (reg_addr == ADDR_W'(i + 1))
          reg_rdata[FIELD_W-1:0] = alm_q[i];
      end
    end
  end
endmodule

// File: rtl/calalm_match.sv
module calalm_match
  import calalm_pkg::*;
(
  input  logic                               strobe,
  input  logic [CTRL_W-1:0]                  ctrl,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal,
  output logic                               hit
);
  logic [NUM_FIELDS-1:0] field_eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign field_eq[i] = ctrl[i] && (alm[i] == cal[i]);
  end

  assign hit = strobe && ctrl[GLOBAL_EN_BIT] && (|field_eq);
endmodule

// File: rtl/calalm_pending.sv
module calalm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (set_i)
      pend_q <= 1'b1;
    else if (clr_i)
      pend_q <= 1'b0;
  end
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
  import calalm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_pulse,
  input  logic [7:0]        cal_sec,
  input  logic [7:0]        cal_min,
  input  logic [7:0]        cal_hour,
  input  logic [7:0]        cal_mday,
  input  logic [7:0]        cal_mon,
  input  logic [11:0]       cal_year,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              alarm_irq
);
  localparam int PAD8 = FIELD_W - 8;

  logic [CTRL_W-1:0]                  ctrl_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_q;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] cal_vec;
  logic                               clr_req;
  logic                               match_hit;
  logic                               pend_q;

  assign cal_vec[0] = {{PAD8{1'b0}}, cal_sec};
  assign cal_vec[1] = {{PAD8{1'b0}}, cal_min};
  assign cal_vec[2] = {{PAD8{1'b0}}, cal_hour};
  assign cal_vec[3] = {{PAD8{1'b0}}, cal_mday};
  assign cal_vec[4] = {{PAD8{1'b0}}, cal_mon};
  assign cal_vec[5] = cal_year;

  calalm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend      (pend_q),
    .ctrl_q    (ctrl_q),
    .alm_q     (alm_q),
    .clr_req   (clr_req),
    .reg_rdata (reg_rdata)
  );

  calalm_match u_match (
    .strobe (sec_pulse),
    .ctrl   (ctrl_q),
    .alm    (alm_q),
    .cal    (cal_vec),
    .hit    (match_hit)
  );

  calalm_pending u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (match_hit),
    .clr_i  (clr_req),
    .pend_q (pend_q)
  );

  assign alarm_irq = pend_q;
endmodule

// File: rtl/calalm_chk.sv
module calalm_chk
  import calalm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               sec_pulse,
  input logic                               reg_we,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [DATA_W-1:0]                  reg_wdata,
  input logic                               alarm_irq,
  input logic                               hit,
  input logic [CTRL_W-1:0]                  ctrl,
  input logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm
);
  logic status_clear;
  assign status_clear = reg_we && (reg_addr == ADDR_W'(RA_STAT)) && reg_wdata[PEND_BIT];

  p_mask_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(RA_SEC)) |=> (alm[0] == {5'b0, $past(reg_wdata[6:0])}));

  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[GLOBAL_EN_BIT] |-> !hit);

  p_strobe_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |-> !hit);

  p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> alarm_irq);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clear && !hit) |=> !alarm_irq);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !status_clear) |=> alarm_irq);

  p_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(sec_pulse));
endmodule

bind calendar_alarm calalm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_pulse (sec_pulse),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .alarm_irq (alarm_irq),
  .hit       (match_hit),
  .ctrl      (ctrl_q),
  .alm       (alm_q)
);

// File: tb/calendar_alarm_tb.sv
`timescale 1ns/1ps
module calendar_alarm_tb;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sec_pulse = 1'b0;
  logic [7:0]        cal_sec = '0, cal_min = '0, cal_hour = '0, cal_mday = '0, cal_mon = '0;
  logic [11:0]       cal_year = '0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              alarm_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  int unsigned m_ctrl = 0;
  int unsigned m_alm [6];
  bit          m_pend = 0;

  always #5 clk = ~clk;

  calendar_alarm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_pulse(sec_pulse),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_mday(cal_mday), .cal_mon(cal_mon), .cal_year(cal_year),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  function automatic int unsigned field_mask(int i);
    case (i)
      0, 1:    return 32'h7f;
      2, 3:    return 32'h3f;
      4:       return 32'h1f;
      default: return 32'hfff;
    endcase
  endfunction

  function automatic bit exp_hit(int unsigned c [6]);
    bit any = 0;
    for (int i = 0; i < 6; i++)
      if (m_ctrl[i] && m_alm[i] == c[i]) any = 1;
    return m_ctrl[6] && any;
  endfunction

  task automatic chk(string req, int unsigned got, int unsigned exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int unsigned a, int unsigned d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 0) m_ctrl = d & 32'h7f;
    else if (a >= 1 && a <= 6) m_alm[a-1] = d & field_mask(a-1);
    else if (a == 7 && d[1]) m_pend = 0;
  endtask

  task automatic rd_chk(string req, int unsigned a, int unsigned exp);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // one calendar second; pulse=0 presents values without a strobe
  task automatic second(string req, int unsigned c [6], bit pulse, bit clr);
    bit h;
    @(negedge clk);
    cal_sec = 8'(c[0]); cal_min = 8'(c[1]); cal_hour = 8'(c[2]);
    cal_mday = 8'(c[3]); cal_mon = 8'(c[4]); cal_year = 12'(c[5]);
    sec_pulse = pulse;
    if (clr) begin reg_we = 1'b1; reg_addr = 3'd7; reg_wdata = 32'h2; end
    h = pulse && exp_hit(c);
    @(negedge clk);
    sec_pulse = 1'b0; reg_we = 1'b0;
    if (h) m_pend = 1;
    else if (clr) m_pend = 0;
    chk(req, alarm_irq, m_pend);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned c [6];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) m_alm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", alarm_irq, 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 readback", a, 0);

    // R2 masking on every register
    for (int a = 0; a < 7; a++) begin
      wr(a, 32'hffff_ffff);
      rd_chk("R2 mask", a, a == 0 ? 32'h7f : field_mask(a-1));
    end
    for (int a = 0; a < 7; a++) wr(a, 0);

    // R3 global enable off
    wr(1, 32'h30); wr(0, 32'h01);
    c = '{32'h30, 0, 0, 0, 0, 0};
    second("R3 no global", c, 1, 0);

    // R6 values present without strobe
    wr(0, 32'h41);
    second("R6 no strobe", c, 0, 0);
    c[0] = 32'h31;
    second("R6 mismatch", c, 1, 0);
    c[0] = 32'h30;
    second("R8 set", c, 1, 0);
    rd_chk("R8 status bit", 7, 32'h2);

    // R10 sticky across later strobes
    c[0] = 32'h45;
    second("R10 sticky", c, 1, 0);
    second("R10 sticky2", c, 0, 0);

    // R9 clearing
    wr(7, 32'h1);
    chk("R9 write0 ignored", alarm_irq, 1);
    wr(7, 32'h2);
    chk("R9 cleared", alarm_irq, 0);
    rd_chk("R9 status", 7, 0);

    // R5 OR semantics: minutes match, hours do not
    wr(2, 32'h15); wr(3, 32'h09); wr(0, 32'h46);
    c = '{32'h00, 32'h15, 32'h10, 0, 0, 0};
    second("R5 any-field", c, 1, 0);
    wr(7, 32'h2);

    // R4 each enable against each matching field
    for (int i = 0; i < 6; i++) wr(i + 1, (i == 5) ? 32'h987 : 32'h11 + i);
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        wr(0, 32'h40 | (1 << j));
        for (int k = 0; k < 6; k++) c[k] = (k == i) ? m_alm[k] : 32'h00;
        second(i == j ? "R4 own field" : "R4 other field", c, 1, 0);
        if (m_pend) wr(7, 32'h2);
      end
    end

    // R7 year hundreds digit
    wr(6, 32'h123); wr(0, 32'h60);
    c = '{0, 0, 0, 0, 0, 32'h023};
    second("R7 hundreds differ", c, 1, 0);
    c[5] = 32'h123;
    second("R7 year match", c, 1, 0);
    wr(7, 32'h2);

    // R11 set and clear in the same cycle
    second("R11 set wins", c, 1, 1);
    second("R11 plain clear", c, 0, 1);

    // random rounds
    for (int it = 0; it < 400; it++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op == 0) wr(0, $urandom());
      else if (op == 1) wr($urandom_range(1, 6), $urandom());
      else if (op == 2) wr(7, $urandom_range(0, 3));
      else begin
        for (int k = 0; k < 6; k++)
          c[k] = $urandom_range(0, 1) ? m_alm[k] : ($urandom() & field_mask(k));
        second("R5 random", c, $urandom_range(0, 3) != 0, $urandom_range(0, 5) == 0);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule